// File: doc/BRIEF.md
# Column-Parallel Single-Slope Converter Digital Back-End

This block holds the digital side of a bank of single-slope converters that run side by side, one per column. A single counter steps in Gray code while an external analog ramp climbs. All channels share that counter, and each channel owns a capture register. When a channel's comparator output first rises, its register freezes the current count. Because the count is in Gray code, a capture taken while the counter is changing is off by at most one code.

A one-cycle `conv_start` pulse begins a conversion. The pulse clears the counter and all capture registers and fixes the resolution for the whole conversion. The counter then advances once per clock until it reaches the last code for the chosen width. At that point `done_o` pulses for one cycle and the counter stops. Channels that never fired take the full-scale code. Choosing a lower resolution makes the conversion shorter.

The results are a parallel bus of codes that stays unchanged until the next `conv_start`. There is no valid/ready handshake on this bus and no back-pressure: a consumer reads the codes at any time after `done_o` and before the next start.

Top module: `ssadc_bank`

## Requirements
- R1: After reset, every channel code is zero and `done_o` is low.
- R2: A clock edge with `conv_start` high zeroes the counter and every channel code. The count after that edge is 0.
- R3: `res_sel` values 0 to 5 select widths 9 to 14 bits. Any value of 6 or above selects 14 bits.
- R4: Codes taken at counts k and k+1 differ in exactly one bit.
- R5: Suppose a channel's comparator goes high during the cycle in which the count is k, and was low in the cycle before. That channel then latches Gray(k) = k XOR (k>>1). The count k is the number of clock edges since the start edge.
- R6: After a channel has captured, further comparator edges leave its code unchanged until the next start.
- R7: A channel whose comparator never rises latches Gray(2^N−1) at the end of the conversion. This code has only bit N−1 set.
- R8: `done_o` is high for exactly the one cycle in which the count is 2^N−1. It is low in the cycles just before and after.
- R9: Code bits at positions N and above are always zero.
- R10: `res_sel` is sampled only at the start edge. Changing it during a conversion does not move the end of the conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_start | input | 1 | One-cycle pulse that starts a conversion |
| res_sel | input | SEL_W | Resolution code (0..5 gives 9..14 bits) |
| cmp_i | input | NCH | One comparator output per channel |
| codes_o | output | NCH*CODE_W | Gray codes, channel i at bits [i*CODE_W +: CODE_W] |
| done_o | output | 1 | One-cycle flag at the terminal count |

## Verification
The hardest case to reach from the ports is a comparator that rises in the very cycle the counter holds its terminal code. In that cycle the normal capture path and the saturation path both act. The bench places one channel's threshold exactly at 2^N−1 and another above it, so both paths run in the same cycle. It also drops and re-raises a comparator after its capture to show the edge is ignored, and it changes `res_sel` partway through a conversion. The bench sweeps all six widths, plus one out-of-range select code.

// File: rtl/ssadc_pkg.sv
package ssadc_pkg;
  localparam int DEF_CODE_W = 14;
  localparam int DEF_MIN_W  = 9;

  function automatic logic [31:0] gray_of(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction
endpackage

// File: rtl/ssadc_res_decode.sv
module ssadc_res_decode #(
  parameter int CODE_W = 14,
  parameter int MIN_W  = 9,
  parameter int SEL_W  = 3,
  localparam int WID_W = $clog2(CODE_W + 1)
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [WID_W-1:0] width_o
);
  always_comb begin
    if (int'(sel_i) > CODE_W - MIN_W) width_o = WID_W'(CODE_W);
    else                              width_o = WID_W'(MIN_W) + WID_W'(sel_i);
  end
endmodule

// File: rtl/ssadc_gray_counter.sv
module ssadc_gray_counter
  import ssadc_pkg::*;
#(
  parameter int CODE_W = 14,
  localparam int WID_W = $clog2(CODE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WID_W-1:0]  width_i,
  output logic [CODE_W-1:0] gray_o,
  output logic [CODE_W-1:0] mask_o,
  output logic              run_o,
  output logic              at_max_o
);
  logic [CODE_W-1:0] bin_q;
  logic [WID_W-1:0]  width_q;
  logic              run_q;

  always_comb begin
    for (int b = 0; b < CODE_W; b++) mask_o[b] = (b < int'(width_q));
  end

  assign at_max_o = run_q && (bin_q == mask_o);
  assign run_o    = run_q;
  assign gray_o   = CODE_W'(gray_of(32'(bin_q)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bin_q   <= '0;
      width_q <= WID_W'(CODE_W);
      run_q   <= 1'b0;
    end else if (start_i) begin
      bin_q   <= '0;
      width_q <= width_i;
      run_q   <= 1'b1;
    end else if (run_q) begin
      if (at_max_o) run_q <= 1'b0;
      else          bin_q <= bin_q + 1'b1;
    end
  end

  // R4: one bit changes per counting step
  a_r4_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !at_max_o && !start_i) |=> ($countones(gray_o ^ $past(gray_o)) == 1));
  // R8: terminal flag lasts one cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (at_max_o && !start_i) |=> !at_max_o);
  // R2: start zeroes the count and arms the counter
  a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (gray_o == '0 && run_o));
  // R10: width mask held during a conversion
  a_r10_width_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !start_i) |=> $stable(mask_o));
endmodule

// File: rtl/ssadc_chan_latch.sv
module ssadc_chan_latch #(
  parameter int CODE_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              run_i,
  input  logic              at_max_i,
  input  logic [CODE_W-1:0] gray_i,
  input  logic [CODE_W-1:0] mask_i,
  input  logic              cmp_i,
  output logic [CODE_W-1:0] code_o
);
  logic cmp_q, captured_q;
  logic [CODE_W-1:0] code_q;
  logic fire;

  assign fire   = run_i && !captured_q && ((cmp_i && !cmp_q) || at_max_i);
  assign code_o = code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q      <= 1'b0;
      captured_q <= 1'b0;
      code_q     <= '0;
    end else begin
      cmp_q <= cmp_i;
      if (start_i) begin
        captured_q <= 1'b0;
        code_q     <= '0;
      end else if (fire) begin
        captured_q <= 1'b1;
        code_q     <= gray_i;
      end
    end
  end

  // R6: a captured code is frozen until restart
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (captured_q && !start_i) |=> $stable(code_q));
  // R7: terminal count always leaves the channel captured
  a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (at_max_i && !start_i) |=> captured_q);
  // R9: no bits above the selected width
  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((code_q & ~mask_i) == '0));
endmodule

// File: rtl/ssadc_bank.sv
module ssadc_bank
  import ssadc_pkg::*;
#(
  parameter int NCH    = 128,
  parameter int CODE_W = DEF_CODE_W,
  parameter int MIN_W  = DEF_MIN_W,
  parameter int SEL_W  = 3,
  localparam int WID_W = $clog2(CODE_W + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  conv_start,
  input  logic [SEL_W-1:0]      res_sel,
  input  logic [NCH-1:0]        cmp_i,
  output logic [NCH*CODE_W-1:0] codes_o,
  output logic                  done_o
);
  logic [WID_W-1:0]  width_d;
  logic [CODE_W-1:0] gray_w, mask_w;
  logic              run_w, at_max_w;

  ssadc_res_decode #(.CODE_W(CODE_W), .MIN_W(MIN_W), .SEL_W(SEL_W)) u_dec (
    .sel_i(res_sel), .width_o(width_d)
  );

  ssadc_gray_counter #(.CODE_W(CODE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start_i(conv_start), .width_i(width_d),
    .gray_o(gray_w), .mask_o(mask_w), .run_o(run_w), .at_max_o(at_max_w)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ssadc_chan_latch #(.CODE_W(CODE_W)) u_lat (
      .clk(clk), .rst_n(rst_n), .start_i(conv_start), .run_i(run_w),
      .at_max_i(at_max_w), .gray_i(gray_w), .mask_i(mask_w),
      .cmp_i(cmp_i[c]), .code_o(codes_o[c*CODE_W +: CODE_W])
    );
  end

  assign done_o = at_max_w;

  // R1: quiet after reset
  a_r1_reset: assert property (@(posedge clk)
    $past(!rst_n) |-> (!done_o && codes_o == '0));
endmodule

// File: tb/tb_ssadc_bank.sv
module tb_ssadc_bank;
  localparam int NCH = 8, CW = 14, MINW = 9, SW = 3;

  logic clk = 0, rst_n = 0, conv_start = 0;
  logic [SW-1:0] res_sel = '0;
  logic [NCH-1:0] cmp = '0;
  logic [NCH*CW-1:0] codes;
  logic done;
  int checks = 0, fails = 0;
  int thr[NCH];

  always #5 clk = ~clk;

  ssadc_bank #(.NCH(NCH), .CODE_W(CW), .MIN_W(MINW), .SEL_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .res_sel(res_sel),
    .cmp_i(cmp), .codes_o(codes), .done_o(done)
  );

  function automatic int gry(int b); return b ^ (b >> 1); endfunction
  function automatic int code_of(int i); return int'(codes[i*CW +: CW]); endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_conv(int sel, int sel_mid, bit glitch);
    int n, m;
    n = (sel < 6) ? MINW + sel : CW;   // R3 mapping
    m = (1 << n) - 1;
    thr[0] = 5;       thr[1] = m / 3; thr[2] = m / 3 + 1; thr[3] = m / 2;
    thr[4] = m;       thr[5] = m + 5; thr[6] = 0;         thr[7] = m - 1;
    @(negedge clk); conv_start = 1; res_sel = SW'(sel); cmp = '0;
    @(negedge clk); conv_start = 0;
    for (int k = 0; k <= m + 2; k++) begin
      for (int i = 0; i < NCH; i++) cmp[i] = (k >= thr[i]);
      if (glitch && k == thr[0] + 10) cmp[0] = 1'b0;
      if (k == 3) res_sel = SW'(sel_mid);
      if (k == 0) begin
        chk("R2 code cleared at start", code_of(5), 0);
        chk("R2 done low at start", int'(done), 0);
      end
      if (k == m - 1) chk("R8 done before end", int'(done), 0);
      if (k == m)     chk(sel_mid != sel ? "R10 done at held width" : "R8 done at end", int'(done), 1);
      if (k == m + 1) chk("R8 done after end", int'(done), 0);
      @(negedge clk);
    end
    for (int i = 0; i < NCH; i++) begin
      if (thr[i] <= m) chk(i == 0 && glitch ? "R6 glitch ignored" : "R5 capture code",
                           code_of(i), gry(thr[i]));
      else chk("R7 saturation code", code_of(i), 1 << (n - 1));
      chk("R9 upper bits zero", code_of(i) >> n, 0);
    end
    chk("R4 adjacent codes one bit apart", $countones(code_of(1) ^ code_of(2)), 1);
    chk(sel > 5 ? "R3 clamp to full width" : "R3 width select", code_of(4), 1 << (n - 1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 done after reset", int'(done), 0);
    for (int i = 0; i < NCH; i++) chk("R1 code after reset", code_of(i), 0);
    run_conv(0, 0, 1'b1);
    run_conv(1, 4, 1'b0);
    run_conv(2, 0, 1'b1);
    run_conv(3, 5, 1'b0);
    run_conv(4, 1, 1'b0);
    run_conv(5, 0, 1'b1);
    run_conv(7, 7, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule